// File: doc/BRIEF.md
# Dual-Slot Receive Frame Assembler

This block takes an incoming Ethernet payload as a byte stream and rebuilds the full wire image in one of two receive buffers. The stored image has eight bytes of preamble and start delimiter, then the payload, then zero fill up to the 60-byte minimum, then a 4-byte CRC-32 frame check sequence. The buffer memory sits outside the block. The block drives a byte-wide write port, with a slot select, an address and the data.

Each slot has a small ownership state. The host arms a slot by writing *loaded* to it. The assembler fills an armed slot and then marks it *pending*, with a byte count. The host empties the slot again after it has consumed the frame. A level interrupt stays high while either slot holds a frame. A ready output tells the upstream source when a frame can be taken.

Payload bytes are written at offset 8 as they arrive. After the last byte, the block writes the padding, the check sequence and the preamble, one byte per cycle. It then commits the slot. The host never sees a half-built buffer, because the slot only turns pending after the last write.

Top module: `rx_frame_assembler`

## Requirements
- R1: Each slot state is 2 bits: 0 is empty, 1 is loaded and 2 is pending. A host write updates the named slot's state on the next clock edge. After reset both states are empty and both counts are 0.
- R2: A frame starting with `rx_sof_i` goes to slot 0 if slot 0 is loaded, otherwise to slot 1 if slot 1 is loaded. It is committed only if that slot is still loaded when assembly ends.
- R3: Buffer bytes 0 to 6 of the slot hold 0x55 and byte 7 holds 0xD5. Payload byte i goes to buffer address 8+i.
- R4: A payload shorter than 60 bytes is followed by zero bytes up to a padded length of 60.
- R5: The 4 bytes after the padded payload hold the CRC-32 of the padded payload, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320, starts from all ones and is inverted at the end. The preamble is not covered.
- R6: A payload longer than BUF_BYTES-12 bytes (2036 by default) is rejected, and its slot's state and count stay unchanged. A payload of exactly 2036 bytes is accepted with a count of 2048.
- R7: On success the slot count becomes the padded length plus 12, and the state becomes pending. Both change on the (P+12)th rising edge after the edge that accepts the last payload byte, where P is the number of pad bytes.
- R8: `irq_o` is high exactly when at least one slot state is pending. It follows host state writes in the cycle after the write edge.
- R9: `ready_o` is high while idle with at least one loaded slot, and while a frame's bytes are being taken, even if the frame is being discarded. It is low while the padding, check sequence and preamble are written.
- R10: A frame that arrives with no slot loaded is discarded. It causes no buffer write and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Payload byte valid |
| rx_sof_i | input | 1 | First byte of a frame |
| rx_eof_i | input | 1 | Last byte of a frame |
| rx_data_i | input | 8 | Payload byte |
| ready_o | output | 1 | Upstream may send |
| host_wr_i | input | 1 | Host state write strobe |
| host_slot_i | input | 1 | Slot addressed by the host write |
| host_state_i | input | 2 | State value written by the host |
| slot0_state_o | output | 2 | Slot 0 state |
| slot1_state_o | output | 2 | Slot 1 state |
| slot0_count_o | output | $clog2(BUF_BYTES+1) | Slot 0 stored byte count |
| slot1_count_o | output | $clog2(BUF_BYTES+1) | Slot 1 stored byte count |
| irq_o | output | 1 | Receive interrupt, level |
| buf_we_o | output | 1 | Buffer write enable |
| buf_slot_o | output | 1 | Buffer slot being written |
| buf_addr_o | output | $clog2(BUF_BYTES) | Buffer byte address |
| buf_data_o | output | 8 | Buffer write data |

## Verification
The assertions check these rules on every cycle:
- A slot becomes pending only from the loaded state, and its count then lies between 72 and the buffer size.
- The check-sequence phase writes exactly four bytes before the preamble starts.
- The start delimiter is the final write, at address 7.
- An overflowed frame never commits.
- Ready is never offered from idle without a loaded slot.

Only the bench scenarios can show:
- the buffer contents, padding and CRC values;
- the slot 0 over slot 1 priority;
- the exact commit cycle;
- the 2036/2037-byte boundary;
- that discarded frames leave the write port silent.

// File: rtl/rxa_pkg.sv
package rxa_pkg;
  localparam logic [1:0] ST_EMPTY   = 2'd0;
  localparam logic [1:0] ST_LOADED  = 2'd1;
  localparam logic [1:0] ST_PENDING = 2'd2;

  localparam int PRE_LEN     = 8;
  localparam int FCS_LEN     = 4;
  localparam int OVH_LEN     = PRE_LEN + FCS_LEN;
  localparam int MIN_PAYLOAD = 60;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  typedef enum logic [2:0] {
    FS_IDLE, FS_RECV, FS_DROP, FS_PAD, FS_FCS, FS_PRE
  } fsm_e;

  function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    c = c_in ^ {24'h0, d};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rxa_crc32.sv
module rxa_crc32 (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_i,
  input  logic        en_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] fcs_o
);
  import rxa_pkg::*;

  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= '1;
    else if (en_i) crc_q <= crc32_step(init_i ? 32'hFFFF_FFFF : crc_q, byte_i);
  end

  assign fcs_o = ~crc_q;
endmodule

// File: rtl/rxa_slot_regs.sv
module rxa_slot_regs #(
  parameter int BUF_BYTES = 2048,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  host_wr_i,
  input  logic                  host_slot_i,
  input  logic [1:0]            host_state_i,
  input  logic                  commit_i,
  input  logic                  commit_slot_i,
  input  logic [CNT_W-1:0]      commit_cnt_i,
  output logic [1:0][1:0]       st_o,
  output logic [1:0][CNT_W-1:0] cnt_o,
  output logic                  sel_valid_o,
  output logic                  sel_slot_o,
  output logic                  irq_o
);
  import rxa_pkg::*;

  localparam logic [CNT_W-1:0] MIN_FRAME_C = CNT_W'(MIN_PAYLOAD + OVH_LEN);
  localparam logic [CNT_W-1:0] MAX_FRAME_C = CNT_W'(BUF_BYTES);

  logic [1:0][1:0]       st_q;
  logic [1:0][CNT_W-1:0] cnt_q;

  for (genvar g = 0; g < 2; g++) begin : g_slot
    logic take;
    logic hwr;
    assign take = commit_i && (commit_slot_i == 1'(g)) && (st_q[g] == ST_LOADED);
    assign hwr  = host_wr_i && (host_slot_i == 1'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g]  <= ST_EMPTY;
        cnt_q[g] <= '0;
      end else if (take) begin
        st_q[g]  <= ST_PENDING;
        cnt_q[g] <= commit_cnt_i;
      end else if (hwr) begin
        st_q[g]  <= host_state_i;
      end
    end

    // R2
    pend_from_loaded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] == ST_PENDING && $past(st_q[g]) != ST_PENDING && !$past(hwr))
        |-> $past(st_q[g]) == ST_LOADED);

    // R7
    count_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[g] == ST_PENDING && $past(st_q[g]) != ST_PENDING && !$past(hwr))
        |-> (cnt_q[g] >= MIN_FRAME_C && cnt_q[g] <= MAX_FRAME_C));
  end

  assign st_o        = st_q;
  assign cnt_o       = cnt_q;
  assign sel_valid_o = (st_q[0] == ST_LOADED) || (st_q[1] == ST_LOADED);
  assign sel_slot_o  = (st_q[0] != ST_LOADED);
  assign irq_o       = (st_q[0] == ST_PENDING) || (st_q[1] == ST_PENDING);
endmodule

// File: rtl/rxa_frame_seq.sv
module rxa_frame_seq #(
  parameter int BUF_BYTES = 2048,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1),
  localparam int ADDR_W   = $clog2(BUF_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic [7:0]        rx_data_i,
  input  logic              sel_valid_i,
  input  logic              sel_slot_i,
  input  logic [31:0]       fcs_i,
  output logic              crc_init_o,
  output logic              crc_en_o,
  output logic [7:0]        crc_byte_o,
  output logic              commit_o,
  output logic              commit_slot_o,
  output logic [CNT_W-1:0]  commit_cnt_o,
  output logic              ready_o,
  output logic              buf_we_o,
  output logic              buf_slot_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o
);
  import rxa_pkg::*;

  localparam logic [CNT_W-1:0] MAX_PL_C = CNT_W'(BUF_BYTES - OVH_LEN);
  localparam logic [CNT_W-1:0] MIN_PL_C = CNT_W'(MIN_PAYLOAD);
  localparam logic [CNT_W-1:0] PRE_C    = CNT_W'(PRE_LEN);
  localparam logic [CNT_W-1:0] OVH_C    = CNT_W'(OVH_LEN);

  fsm_e             fsm_q, fsm_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [2:0]       idx_q, idx_d;
  logic             ovf_q, ovf_d;
  logic             slot_q, slot_d;
  logic             we_d;
  logic [ADDR_W-1:0] addr_d;
  logic [7:0]       data_d;

  always_comb begin
    fsm_d      = fsm_q;
    len_d      = len_q;
    idx_d      = idx_q;
    ovf_d      = ovf_q;
    slot_d     = slot_q;
    we_d       = 1'b0;
    addr_d     = '0;
    data_d     = '0;
    crc_init_o = 1'b0;
    crc_en_o   = 1'b0;
    crc_byte_o = rx_data_i;
    commit_o   = 1'b0;
    unique case (fsm_q)
      FS_IDLE: if (rx_valid_i && rx_sof_i) begin
        if (sel_valid_i) begin
          slot_d     = sel_slot_i;
          we_d       = 1'b1;
          addr_d     = ADDR_W'(PRE_C);
          data_d     = rx_data_i;
          len_d      = CNT_W'(1);
          ovf_d      = 1'b0;
          crc_init_o = 1'b1;
          crc_en_o   = 1'b1;
          fsm_d      = rx_eof_i ? FS_PAD : FS_RECV;
        end else if (!rx_eof_i) begin
          fsm_d = FS_DROP;
        end
      end
      FS_RECV: if (rx_valid_i) begin
        if (len_q >= MAX_PL_C) begin
          ovf_d = 1'b1;
        end else begin
          we_d     = 1'b1;
          addr_d   = ADDR_W'(PRE_C + len_q);
          data_d   = rx_data_i;
          len_d    = len_q + CNT_W'(1);
          crc_en_o = 1'b1;
        end
        if (rx_eof_i) begin
          idx_d = '0;
          if (ovf_d)                fsm_d = FS_IDLE;
          else if (len_d < MIN_PL_C) fsm_d = FS_PAD;
          else                      fsm_d = FS_FCS;
        end
      end
      FS_DROP: if (rx_valid_i && rx_eof_i) fsm_d = FS_IDLE;
      FS_PAD: begin
        we_d       = 1'b1;
        addr_d     = ADDR_W'(PRE_C + len_q);
        crc_byte_o = 8'h00;
        crc_en_o   = 1'b1;
        len_d      = len_q + CNT_W'(1);
        if (len_d == MIN_PL_C) begin
          fsm_d = FS_FCS;
          idx_d = '0;
        end
      end
      FS_FCS: begin
        we_d   = 1'b1;
        addr_d = ADDR_W'(PRE_C + len_q + CNT_W'(idx_q));
        data_d = fcs_i[{idx_q[1:0], 3'b000} +: 8];
        idx_d  = idx_q + 3'd1;
        if (idx_q == 3'(FCS_LEN - 1)) begin
          fsm_d = FS_PRE;
          idx_d = '0;
        end
      end
      FS_PRE: begin
        we_d   = 1'b1;
        addr_d = ADDR_W'(idx_q);
        data_d = (idx_q == 3'(PRE_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
        idx_d  = idx_q + 3'd1;
        if (idx_q == 3'(PRE_LEN - 1)) begin
          commit_o = 1'b1;
          fsm_d    = FS_IDLE;
        end
      end
      default: fsm_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q      <= FS_IDLE;
      len_q      <= '0;
      idx_q      <= '0;
      ovf_q      <= 1'b0;
      slot_q     <= 1'b0;
      buf_we_o   <= 1'b0;
      buf_slot_o <= 1'b0;
      buf_addr_o <= '0;
      buf_data_o <= '0;
    end else begin
      fsm_q      <= fsm_d;
      len_q      <= len_d;
      idx_q      <= idx_d;
      ovf_q      <= ovf_d;
      slot_q     <= slot_d;
      buf_we_o   <= we_d;
      buf_slot_o <= slot_d;
      buf_addr_o <= addr_d;
      buf_data_o <= data_d;
    end
  end

  assign commit_slot_o = slot_q;
  assign commit_cnt_o  = len_q + OVH_C;
  assign ready_o       = (fsm_q == FS_IDLE && sel_valid_i) || fsm_q == FS_RECV || fsm_q == FS_DROP;

  // R5
  fcs_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == FS_FCS && idx_q == 3'(FCS_LEN - 1)) |=> (fsm_q == FS_PRE && buf_we_o));

  // R3
  sfd_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsm_q == FS_PRE && idx_q == 3'(PRE_LEN - 1))
      |=> (buf_we_o && buf_data_o == SFD_BYTE && buf_addr_o == ADDR_W'(PRE_LEN - 1) && fsm_q == FS_IDLE));

  // R6
  ovf_no_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> !commit_o);

  // R9
  ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && fsm_q == FS_IDLE) |-> sel_valid_i);
endmodule

// File: rtl/rx_frame_assembler.sv
module rx_frame_assembler #(
  parameter int BUF_BYTES = 2048
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           rx_valid_i,
  input  logic                           rx_sof_i,
  input  logic                           rx_eof_i,
  input  logic [7:0]                     rx_data_i,
  output logic                           ready_o,
  input  logic                           host_wr_i,
  input  logic                           host_slot_i,
  input  logic [1:0]                     host_state_i,
  output logic [1:0]                     slot0_state_o,
  output logic [1:0]                     slot1_state_o,
  output logic [$clog2(BUF_BYTES+1)-1:0] slot0_count_o,
  output logic [$clog2(BUF_BYTES+1)-1:0] slot1_count_o,
  output logic                           irq_o,
  output logic                           buf_we_o,
  output logic                           buf_slot_o,
  output logic [$clog2(BUF_BYTES)-1:0]   buf_addr_o,
  output logic [7:0]                     buf_data_o
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);

  logic                  crc_init, crc_en;
  logic [7:0]            crc_byte;
  logic [31:0]           fcs;
  logic                  commit, commit_slot;
  logic [CNT_W-1:0]      commit_cnt;
  logic                  sel_valid, sel_slot;
  logic [1:0][1:0]       st;
  logic [1:0][CNT_W-1:0] cnt;

  rxa_crc32 u_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .init_i (crc_init),
    .en_i   (crc_en),
    .byte_i (crc_byte),
    .fcs_o  (fcs)
  );

  rxa_frame_seq #(.BUF_BYTES(BUF_BYTES)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rx_valid_i    (rx_valid_i),
    .rx_sof_i      (rx_sof_i),
    .rx_eof_i      (rx_eof_i),
    .rx_data_i     (rx_data_i),
    .sel_valid_i   (sel_valid),
    .sel_slot_i    (sel_slot),
    .fcs_i         (fcs),
    .crc_init_o    (crc_init),
    .crc_en_o      (crc_en),
    .crc_byte_o    (crc_byte),
    .commit_o      (commit),
    .commit_slot_o (commit_slot),
    .commit_cnt_o  (commit_cnt),
    .ready_o       (ready_o),
    .buf_we_o      (buf_we_o),
    .buf_slot_o    (buf_slot_o),
    .buf_addr_o    (buf_addr_o),
    .buf_data_o    (buf_data_o)
  );

  rxa_slot_regs #(.BUF_BYTES(BUF_BYTES)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .host_wr_i     (host_wr_i),
    .host_slot_i   (host_slot_i),
    .host_state_i  (host_state_i),
    .commit_i      (commit),
    .commit_slot_i (commit_slot),
    .commit_cnt_i  (commit_cnt),
    .st_o          (st),
    .cnt_o         (cnt),
    .sel_valid_o   (sel_valid),
    .sel_slot_o    (sel_slot),
    .irq_o         (irq_o)
  );

  assign slot0_state_o = st[0];
  assign slot1_state_o = st[1];
  assign slot0_count_o = cnt[0];
  assign slot1_count_o = cnt[1];
endmodule

// File: tb/test_rx_frame_assembler.sv
`timescale 1ns/1ps
module test_rx_frame_assembler;
  localparam int BUF = 2048;
  localparam int CW  = $clog2(BUF + 1);
  localparam int AW  = $clog2(BUF);

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0;
  logic [7:0] rx_data = 0;
  logic host_wr = 0, host_slot = 0;
  logic [1:0] host_state = 0;
  logic ready_o, irq_o, buf_we_o, buf_slot_o;
  logic [1:0] slot0_state_o, slot1_state_o;
  logic [CW-1:0] slot0_count_o, slot1_count_o;
  logic [AW-1:0] buf_addr_o;
  logic [7:0] buf_data_o;

  always #2 clk = ~clk;

  rx_frame_assembler #(.BUF_BYTES(BUF)) i_rx_frame_assembler (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_sof_i(rx_sof),
    .rx_eof_i(rx_eof), .rx_data_i(rx_data), .ready_o(ready_o),
    .host_wr_i(host_wr), .host_slot_i(host_slot), .host_state_i(host_state),
    .slot0_state_o(slot0_state_o), .slot1_state_o(slot1_state_o),
    .slot0_count_o(slot0_count_o), .slot1_count_o(slot1_count_o),
    .irq_o(irq_o), .buf_we_o(buf_we_o), .buf_slot_o(buf_slot_o),
    .buf_addr_o(buf_addr_o), .buf_data_o(buf_data_o)
  );

  int checks = 0, failures = 0;
  bit chk_on = 0;
  int exp_st[2];
  int exp_cnt[2];
  int mode = 0; // 0 idle, 1 taking, 2 discarding, 3 assembling tail
  logic [7:0] mem [2][BUF];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_crc(logic [7:0] q[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (q[i]) begin
      c ^= {24'h0, q[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  // per-clock model comparison
  always @(negedge clk) begin
    if (buf_we_o) mem[buf_slot_o][buf_addr_o] = buf_data_o;
    if (chk_on) begin
      int exp_rdy, exp_irq;
      exp_rdy = ((mode == 0 && (exp_st[0] == 1 || exp_st[1] == 1)) || mode == 1 || mode == 2) ? 1 : 0;
      exp_irq = (exp_st[0] == 2 || exp_st[1] == 2) ? 1 : 0;
      checks++;
      if (slot0_state_o != exp_st[0] || slot1_state_o != exp_st[1] ||
          slot0_count_o != exp_cnt[0] || slot1_count_o != exp_cnt[1] ||
          irq_o != exp_irq || ready_o != exp_rdy) begin
        failures++;
        $display("FAIL R1/R2/R6/R7/R8/R9 st=%0d/%0d cnt=%0d/%0d irq=%0d rdy=%0d expected st=%0d/%0d cnt=%0d/%0d irq=%0d rdy=%0d at %0t",
                 slot0_state_o, slot1_state_o, slot0_count_o, slot1_count_o, irq_o, ready_o,
                 exp_st[0], exp_st[1], exp_cnt[0], exp_cnt[1], exp_irq, exp_rdy, $time);
      end
      if (mode == 2) begin
        checks++;
        if (buf_we_o) begin
          failures++;
          $display("FAIL R10 buf_we=%0d expected=0 at %0t", buf_we_o, $time);
        end
      end
    end
  end

  task automatic host_set(input int slot, input int val);
    host_wr = 1; host_slot = 1'(slot); host_state = 2'(val);
    @(posedge clk); #1;
    exp_st[slot] = val;
    host_wr = 0;
  endtask

  task automatic send_frame(input int n, input int seed);
    logic [7:0] pl[$];
    logic [7:0] padq[$];
    logic [7:0] ef[$];
    logic [31:0] c;
    bit drop, ovf;
    int tgt, padded, bad, first;
    for (int i = 0; i < n; i++) pl.push_back(8'((seed * 37 + i * 7 + (i >> 3)) & 8'hFF));
    drop = !(exp_st[0] == 1 || exp_st[1] == 1);
    tgt  = (exp_st[0] == 1) ? 0 : 1;
    ovf  = n > BUF - 12;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1); rx_data = pl[i];
      @(posedge clk); #1;
      if (i == 0) mode = drop ? 2 : 1;
      if (i == n - 1) mode = (drop || ovf) ? 0 : 3;
    end
    rx_valid = 0; rx_sof = 0; rx_eof = 0;
    if (!drop && !ovf) begin
      padded = (n < 60) ? 60 : n;
      repeat (padded - n + 11) @(posedge clk);
      @(posedge clk); #1;
      exp_st[tgt] = 2; exp_cnt[tgt] = padded + 12; mode = 0;
      @(negedge clk); @(posedge clk); #1;
      padq = pl;
      while (padq.size() < 60) padq.push_back(8'h00);
      c = ref_crc(padq);
      for (int i = 0; i < 7; i++) ef.push_back(8'h55);
      ef.push_back(8'hD5);
      foreach (padq[i]) ef.push_back(padq[i]);
      for (int k = 0; k < 4; k++) ef.push_back(c[8*k +: 8]);
      bad = 0; first = -1;
      foreach (ef[i]) if (mem[tgt][i] !== ef[i]) begin bad++; if (first < 0) first = i; end
      checks++;
      if (bad != 0) begin
        failures++;
        $display("FAIL R3/R4/R5 slot %0d byte %0d actual=%02h expected=%02h (%0d mismatches)",
                 tgt, first, mem[tgt][first], ef[first], bad);
      end
    end
    repeat (2) @(posedge clk); #1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    exp_st[0] = 0; exp_st[1] = 0; exp_cnt[0] = 0; exp_cnt[1] = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset slot0 state", slot0_state_o, 0);
    chk("R1 reset slot1 count", slot1_count_o, 0);
    chk("R9 reset ready", ready_o, 0);
    chk_on = 1;
    @(posedge clk); #1;

    send_frame(10, 1);                       // R10 nothing loaded
    chk("R10 slot0 unchanged", slot0_state_o, 0);

    host_set(0, 1); host_set(1, 1);
    chk("R9 ready when loaded", ready_o, 1);

    send_frame(20, 3);                       // short -> slot0
    chk("R4 padded count", slot0_count_o, 72);
    send_frame(100, 5);                      // -> slot1
    chk("R7 count", slot1_count_o, 112);
    chk("R8 irq with pending", irq_o, 1);
    chk("R9 ready none loaded", ready_o, 0);

    send_frame(30, 7);                       // both pending -> dropped
    chk("R10 slot1 kept", slot1_count_o, 112);

    host_set(0, 0);
    chk("R8 irq one pending", irq_o, 1);
    host_set(1, 0);
    chk("R8 irq cleared", irq_o, 0);

    host_set(1, 1);
    send_frame(60, 9);                       // only slot1 loaded
    chk("R2 slot1 used", slot1_state_o, 2);
    chk("R4 exact 60", slot1_count_o, 72);

    host_set(1, 1); host_set(0, 1);
    send_frame(1, 11);                       // priority slot0
    chk("R2 slot0 priority", slot0_count_o, 72);
    chk("R2 slot1 untouched", slot1_state_o, 1);

    send_frame(2037, 13);                    // overflow
    chk("R6 overflow state", slot1_state_o, 1);
    send_frame(2036, 15);                    // boundary
    chk("R6 boundary count", slot1_count_o, 2048);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule